// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block sits in the system clock domain and runs one conversion at a time on an eight-input, 12-bit successive-approximation converter that has a parallel output bus. The host hands it a channel number through a valid/ready request. The controller lowers chip select and drives the channel onto the address lines. It then pulses the active-low write strobe to start the conversion and follows the converter's busy line through its low phase and back high. Once busy is high again it reads the 12-bit word with an active-low read strobe. The word and its channel number go back to the host as one valid/ready transfer.

Strobe widths and the address setup time are given as parameters in nanoseconds. Each is turned into a count of system clock cycles, rounded up. The busy line is asynchronous, so it passes through a two-flop synchronizer before any decision is taken on it. A cycle budget guards the wait. If busy does not complete its low-then-high sequence within the budget, the controller releases the bus and raises an error flag. After every read, the two low address bits are parked at zero before read and chip select rise, so that the converter is never told to power down.

Top module: `adc_host_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle with all three strobes high. It drops in the cycle after a request is accepted and stays low until the response has been taken.
- R2: After a request is accepted, `adc_cs_n` is low and `adc_addr` equals the requested channel for exactly ceil(ADDR_SETUP_NS/CLK_PERIOD_NS) cycles before `adc_wr_n` falls. `adc_addr` keeps that value for as long as `adc_wr_n` is low.
- R3: `adc_wr_n` stays low for exactly ceil(WR_PULSE_NS/CLK_PERIOD_NS) clock cycles per conversion.
- R4: `adc_busy` is high when idle and low while converting. The read strobe never falls before the synchronized busy has been seen low and then high. `adc_rd_n` falls exactly 3 clock edges after the edge at which `adc_busy` was sampled high again: two synchronizer flops plus one state register.
- R5: `adc_rd_n` stays low for exactly ceil(RD_PULSE_NS/CLK_PERIOD_NS) cycles and never overlaps a low `adc_wr_n`. The response word is `adc_data` as sampled in the last cycle of that read pulse.
- R6: Whenever `adc_cs_n` or `adc_rd_n` rises, `adc_addr[1:0]` is 00.
- R7: `rsp_valid` carries `rsp_data` and `rsp_chan` (the requested channel). While `rsp_ready` is low, the response and its valid flag hold steady. After the handshake, the controller returns to idle in the next cycle.
- R8: The busy wait has a budget of BUSY_TIMEOUT_CYC cycles, counted from the cycle after the one in which `adc_wr_n` returns high. If busy does not fall and rise again within it, `timeout_err` is set. This happens BUSY_TIMEOUT_CYC+1 cycles after `adc_wr_n` rose. At the same time chip select is released, no response is produced and `req_ready` returns. The flag clears when the next request is accepted.
- R9: If the rising edge of busy is detected in the same cycle that the budget runs out, the conversion completes normally and no error is flagged.
- R10: While `rst_n` is low, all strobes are high, `adc_addr` is zero, and `rsp_valid`, `timeout_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_chan | input | CH_W | Channel to convert |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Host takes the result |
| rsp_data | output | DATA_W | Conversion result |
| rsp_chan | output | CH_W | Channel the result belongs to |
| timeout_err | output | 1 | Last conversion ran out of its busy budget |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Conversion start strobe, active low |
| adc_rd_n | output | 1 | Output enable strobe, active low |
| adc_addr | output | CH_W | Channel address lines |
| adc_busy | input | 1 | Converter busy line, low while converting (asynchronous) |
| adc_data | input | DATA_W | Converter parallel result bus |

## Verification
Two things can happen in the same clock cycle: the detected return of busy, and the last cycle of the timeout budget. The bench lengthens its converter model's busy-low time to the value at which both land in one cycle. It expects a normal result with the correct word and no error flag. It then lengthens that time by one cycle and expects the timeout path, with the error flag raised at its fixed distance from the write strobe's rise and no response. A channel sweep at several conversion lengths and host back-pressure delays covers the strobe widths, the synchronizer latency and the address parking on every release.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_CONV_WAIT,
        ST_DONE_WAIT,
        ST_READ,
        ST_RESP
    } host_state_e;

    // Whole clock cycles covering a time in ns, never less than one.
    function automatic int cycles_for(input int time_ns, input int period_ns);
        int c;
        c = (time_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async,
    output logic busy_sync,
    output logic busy_rise
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value.
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], busy_async};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy_sync = sh_q[STAGES-1];
    assign busy_rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/adc_down_timer.sv
module adc_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int CLK_PERIOD_NS    = 10,
    parameter int WR_PULSE_NS      = 35,
    parameter int ADDR_SETUP_NS    = 10,
    parameter int RD_PULSE_NS      = 40,
    parameter int BUSY_TIMEOUT_CYC = 64,
    parameter int DATA_W           = 12,
    parameter int CH_W             = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_chan,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CH_W-1:0]   rsp_chan,
    output logic              timeout_err,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    output logic [CH_W-1:0]   adc_addr,
    input  logic              adc_busy,
    input  logic [DATA_W-1:0] adc_data
);
    localparam int SETUP_CYC = cycles_for(ADDR_SETUP_NS, CLK_PERIOD_NS);
    localparam int WR_CYC    = cycles_for(WR_PULSE_NS, CLK_PERIOD_NS);
    localparam int RD_CYC    = cycles_for(RD_PULSE_NS, CLK_PERIOD_NS);
    localparam int PH_MAX    = (SETUP_CYC > WR_CYC) ?
                               ((SETUP_CYC > RD_CYC) ? SETUP_CYC : RD_CYC) :
                               ((WR_CYC > RD_CYC) ? WR_CYC : RD_CYC);
    localparam int PH_W      = $clog2(PH_MAX + 1);
    localparam int TO_W      = $clog2(BUSY_TIMEOUT_CYC + 1);

    typedef struct packed {
        host_state_e       st;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] data;
        logic              err;
        logic              cs_n;
        logic              wr_n;
        logic              rd_n;
        logic [CH_W-1:0]   addr;
    } host_regs_t;

    host_regs_t      r_d, r_q;
    logic            ph_load, ph_exp;
    logic [PH_W-1:0] ph_val;
    logic            wd_load, wd_exp;
    logic            busy_s, busy_rise;

    adc_busy_sync #(.STAGES(2)) busy_sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_async (adc_busy),
        .busy_sync  (busy_s),
        .busy_rise  (busy_rise)
    );

    adc_down_timer #(.W(PH_W)) phase_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_exp)
    );

    adc_down_timer #(.W(TO_W)) wait_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wd_load),
        .load_val (TO_W'(BUSY_TIMEOUT_CYC - 1)),
        .expired  (wd_exp)
    );

    always_comb begin
        r_d     = r_q;
        ph_load = 1'b0;
        ph_val  = '0;
        wd_load = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_SETUP;
                    r_d.chan = req_chan;
                    r_d.err  = 1'b0;
                    ph_load  = 1'b1;
                    ph_val   = PH_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (ph_exp) begin
                    r_d.st  = ST_STROBE;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(WR_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (ph_exp) begin
                    r_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                r_d.st  = ST_CONV_WAIT;
                wd_load = 1'b1;
            end
            ST_CONV_WAIT: begin
                if (!busy_s) begin
                    r_d.st = ST_DONE_WAIT;
                end else if (wd_exp) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_DONE_WAIT: begin
                // completion wins over an expiring budget
                if (busy_rise) begin
                    r_d.st  = ST_READ;
                    ph_load = 1'b1;
                    ph_val  = PH_W'(RD_CYC - 1);
                end else if (wd_exp) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
            ST_READ: begin
                if (ph_exp) begin
                    r_d.st   = ST_RESP;
                    r_d.data = adc_data;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // pin levels registered from the state being entered
        r_d.cs_n = 1'b0;
        r_d.wr_n = 1'b1;
        r_d.rd_n = 1'b1;
        r_d.addr = '0;
        case (r_d.st)
            ST_IDLE, ST_RESP: r_d.cs_n = 1'b1;
            ST_SETUP, ST_HOLD: r_d.addr = r_d.chan;
            ST_STROBE: begin
                r_d.wr_n = 1'b0;
                r_d.addr = r_d.chan;
            end
            ST_READ: r_d.rd_n = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.chan <= '0;
            r_q.data <= '0;
            r_q.err  <= 1'b0;
            r_q.cs_n <= 1'b1;
            r_q.wr_n <= 1'b1;
            r_q.rd_n <= 1'b1;
            r_q.addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign rsp_valid   = (r_q.st == ST_RESP);
    assign rsp_data    = r_q.data;
    assign rsp_chan    = r_q.chan;
    assign timeout_err = r_q.err;
    assign adc_cs_n    = r_q.cs_n;
    assign adc_wr_n    = r_q.wr_n;
    assign adc_rd_n    = r_q.rd_n;
    assign adc_addr    = r_q.addr;

    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (adc_cs_n && adc_wr_n && adc_rd_n)); // R1
    AST_ADDR_HELD_IN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_wr_n |=> $stable(adc_addr)); // R2
    AST_RD_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> busy_s); // R4
    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_wr_n && !adc_rd_n)); // R5
    AST_PARK_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_cs_n) || $rose(adc_rd_n)) |-> (adc_addr[1:0] == 2'b00)); // R6
    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_chan))); // R7
    AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !rsp_valid); // R8

endmodule

// File: tb/adc_host_ctrl_tb.sv
module adc_host_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WR_NS      = 35;
    localparam int SETUP_NS   = 10;
    localparam int RD_NS      = 40;
    localparam int TO_CYC     = 64;
    localparam int EXP_WR     = (WR_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_SETUP  = (SETUP_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_RD     = (RD_NS + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_chan = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [11:0] rsp_data;
    logic [2:0]  rsp_chan;
    logic        timeout_err;
    logic        adc_cs_n, adc_wr_n, adc_rd_n;
    logic [2:0]  adc_addr;
    logic        adc_busy;
    logic [11:0] adc_data;

    int total = 0;
    int bad = 0;

    // converter model controls
    int          mode = 0;      // 0 normal, 1 busy never falls, 2 busy never rises
    int          conv_len = 8;
    int          k_exp = 0;
    int          cur_chan = 0;
    logic        busy_m = 1'b1;
    int          busy_cnt = 0;
    logic [2:0]  lat_chan = '0;
    logic [11:0] result_m = '0;
    logic        wr_seen = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_host_ctrl #(
        .CLK_PERIOD_NS    (CLK_PERIOD),
        .WR_PULSE_NS      (WR_NS),
        .ADDR_SETUP_NS    (SETUP_NS),
        .RD_PULSE_NS      (RD_NS),
        .BUSY_TIMEOUT_CYC (TO_CYC),
        .DATA_W           (12),
        .CH_W             (3)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_chan    (req_chan),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_data    (rsp_data),
        .rsp_chan    (rsp_chan),
        .timeout_err (timeout_err),
        .adc_cs_n    (adc_cs_n),
        .adc_wr_n    (adc_wr_n),
        .adc_rd_n    (adc_rd_n),
        .adc_addr    (adc_addr),
        .adc_busy    (adc_busy),
        .adc_data    (adc_data)
    );

    assign adc_busy = busy_m;
    assign adc_data = (!adc_cs_n && !adc_rd_n) ? result_m : 12'h000;

    function automatic logic [11:0] pattern(input int ch, input int k);
        return 12'((ch * 331 + k * 97 + 17) & 12'hFFF);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model, updates just after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            busy_m   = 1'b1;
            busy_cnt = 0;
            wr_seen  = 1'b1;
        end else begin
            if (wr_seen && !adc_wr_n && !adc_cs_n) begin
                if (mode != 1) begin
                    busy_m   = 1'b0;
                    busy_cnt = conv_len;
                end
            end else if (!busy_m) begin
                if (adc_cs_n) begin
                    busy_m = 1'b1;
                end else if (mode == 0) begin
                    if (busy_cnt <= 1) begin
                        busy_m   = 1'b1;
                        result_m = pattern(int'(lat_chan), k_exp);
                    end else begin
                        busy_cnt--;
                    end
                end
            end
            if (!wr_seen && adc_wr_n && !adc_cs_n) lat_chan = adc_addr;
            wr_seen = adc_wr_n;
        end
    end

    // pin monitors, sampled on falling edges
    logic prev_cs = 1'b1, prev_rd = 1'b1, prev_wr = 1'b1, prev_busy = 1'b1;
    int   pre_cnt = 0, wr_len = 0, rd_len = 0, lat_cnt = 0;
    bit   lat_arm = 1'b0, addr_ok = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            // R2 setup window and R3 strobe width
            if (!adc_wr_n && prev_wr) begin
                check(pre_cnt == EXP_SETUP, "R2 setup cycles before write", pre_cnt, EXP_SETUP);
                wr_len  = 0;
                addr_ok = 1'b1;
            end
            if (!adc_wr_n) begin
                wr_len++;
                if (int'(adc_addr) != cur_chan) addr_ok = 1'b0;
            end
            if (adc_wr_n && !prev_wr) begin
                check(wr_len == EXP_WR, "R3 write strobe width", wr_len, EXP_WR);
                check(addr_ok, "R2 address stable during write", int'(addr_ok), 1);
            end
            if (adc_cs_n || !adc_wr_n) pre_cnt = 0;
            else if (int'(adc_addr) == cur_chan) pre_cnt++;
            // R4 busy return to read strobe latency
            if (lat_arm) begin
                lat_cnt++;
                if (!adc_rd_n) begin
                    check(lat_cnt == 3, "R4 busy rise to read latency", lat_cnt, 3);
                    lat_arm = 1'b0;
                end
            end
            if (adc_busy && !prev_busy && !adc_cs_n) begin
                lat_arm = 1'b1;
                lat_cnt = 0;
            end
            // R5 read width
            if (!adc_rd_n) rd_len++;
            if (adc_rd_n && !prev_rd) begin
                check(rd_len == EXP_RD, "R5 read strobe width", rd_len, EXP_RD);
            end
            if (adc_rd_n) begin
                if (!prev_rd) rd_len = 0;
            end
            // R6 parking on release
            if ((adc_cs_n && !prev_cs) || (adc_rd_n && !prev_rd)) begin
                check(adc_addr[1:0] == 2'b00, "R6 low address bits on release",
                      int'(adc_addr[1:0]), 0);
            end
        end
        prev_cs   = adc_cs_n;
        prev_rd   = adc_rd_n;
        prev_wr   = adc_wr_n;
        prev_busy = adc_busy;
    end

    task automatic issue(input int ch);
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = 3'(ch);
        cur_chan  = ch;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R1 ready low after accept", int'(req_ready), 0);
        check(!timeout_err, "R8 error cleared on accept", int'(timeout_err), 0);
    endtask

    task automatic do_conv(input int ch, input int hold);
        int          n;
        logic [11:0] held;
        issue(ch);
        n = 0;
        while (!rsp_valid && n < 500) begin
            check(!req_ready, "R1 ready low while busy", int'(req_ready), 0);
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R7 response appears", int'(rsp_valid), 1);
        check(rsp_data == pattern(ch, k_exp), "R5 result word", int'(rsp_data),
              int'(pattern(ch, k_exp)));
        check(int'(rsp_chan) == ch, "R7 result channel", int'(rsp_chan), ch);
        held = rsp_data;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(rsp_valid && rsp_data == held && int'(rsp_chan) == ch,
                  "R7 held under backpressure", int'(rsp_data), int'(held));
            check(!req_ready, "R1 ready low while response pending", int'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check(!rsp_valid && req_ready, "R7 back to idle after handshake",
              int'(rsp_valid), 0);
        k_exp++;
    endtask

    task automatic do_timeout(input int m, input string tag);
        int n;
        mode = m;
        issue(5);
        n = 0;
        while (adc_wr_n && n < 100) begin @(negedge clk); n++; end
        while (!adc_wr_n && n < 100) begin @(negedge clk); n++; end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!timeout_err && n < 400);
        check(n == TO_CYC + 1, tag, n, TO_CYC + 1);
        check(adc_cs_n && req_ready && !rsp_valid, "R8 bus released after timeout",
              int'(adc_cs_n), 1);
        repeat (5) @(negedge clk);
        check(!rsp_valid && timeout_err, "R8 no response and flag held",
              int'(rsp_valid), 0);
        mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset levels
        check(adc_cs_n && adc_wr_n && adc_rd_n, "R10 strobes high in reset",
              int'({adc_cs_n, adc_wr_n, adc_rd_n}), 7);
        check(adc_addr == 3'd0 && !rsp_valid && !timeout_err, "R10 outputs clear in reset",
              int'(adc_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1 ready when idle", int'(req_ready), 1);

        for (int rep = 0; rep < 3; rep++) begin
            for (int ch = 0; ch < 8; ch++) begin
                conv_len = 6 + rep * 5 + ch;
                do_conv(ch, (ch + rep) % 3);
            end
        end

        do_timeout(1, "R8 timeout when busy never falls");
        conv_len = 9;
        do_conv(3, 0);
        do_timeout(2, "R8 timeout when busy never returns");
        do_conv(6, 1);

        // R9 busy return in the very cycle the budget expires: completion wins
        conv_len = TO_CYC + 2;
        do_conv(7, 0);
        // one cycle later the budget wins
        conv_len = TO_CYC + 3;
        do_timeout(0, "R9 late busy return times out");
        conv_len = 7;
        do_conv(2, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule